// File: doc/BRIEF.md
# Shuffled Pseudo-Random Bit Source

This block produces one pseudo-random bit per enabled clock cycle. The bits have less of the shift-register structure that a bare LFSR shows. A 31-bit maximal-length LFSR, called the primary generator, does not drive the output directly. Each new bit it makes is written into a 64-entry bit memory that has separate read and write paths. A second, 7-bit maximal-length LFSR chooses the memory location. Its period (127) differs from the primary period (2^31 − 1).

On every running cycle the block reads the bit at the chosen location and registers it as the output. In the same cycle it writes the newest primary bit into that location. The memory therefore changes one bit at a time and is never emptied and refilled in bulk. Because the low six bits of the address LFSR pass through every value within one period, no stored bit waits unread for more than 127 running cycles.

Control is a two-state machine:
- **FILL**: the memory is loaded in address order from the primary generator.
- **RUN**: the shuffled output is produced.

The machine has these transitions:
- Reset enters FILL.
- FILL moves to RUN on the enabled cycle that writes the last entry.
- A seed load from either state returns to FILL with the fill counter cleared.
- With enable low and no seed load, both states hold.

Top module: `bit_shuffler`

## Requirements
- R1: While reset is active and after it is released, `out_valid` is 0, the machine is in FILL, and both LFSRs hold the value 1.
- R2: After reset or a seed load, the first 64 enabled cycles fill the memory, and `out_valid` stays 0 during all of them.
- R3: The primary generator is 31 bits wide. Its new bit is bit 30 XOR bit 27. The state shifts toward the MSB, with the new bit entering bit 0. That new bit is the value written to memory. The generator advances once on every enabled cycle, in both FILL and RUN.
- R4: The address generator is 7 bits wide. Its new bit is bit 6 XOR bit 5, and it shifts the same way as the primary generator. The memory address is bits 5:0 of its current state. It advances only on enabled RUN cycles, so every address is read within 127 RUN cycles.
- R5: On an enabled RUN cycle, the output bit is the value the addressed entry held before this cycle's write. That entry then takes the primary generator's new bit.
- R6: During FILL, entry k (k = 0 to 63) receives the k-th new bit of the primary generator.
- R7: With `en` low and `seed_load` low, neither LFSR nor the memory changes, and `out_valid` is 0 in the next cycle.
- R8: `seed_load` has priority over `en`. It loads both seeds, replacing an all-zero seed with 1, and restarts FILL. `out_valid` is 0 in the next cycle.
- R9: `out_valid` is 1 exactly in the cycle after an enabled RUN cycle, and `out_bit` then carries that cycle's bit. At all other times `out_bit` keeps its last value.
- R10: Over 32768 consecutive outputs, the fraction of ones lies between 0.45 and 0.55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance one step this cycle |
| seed_load | input | 1 | Load both seeds and restart the fill |
| pri_seed | input | 31 | Seed for the primary generator |
| adr_seed | input | 7 | Seed for the address generator |
| out_bit | output | 1 | Shuffled bit |
| out_valid | output | 1 | `out_bit` carries a new bit this cycle |

## Verification
A corrupted memory entry or primary state shows as a wrong output bit. An entry is wrong at most 127 RUN cycles after it goes bad, and a wrong primary bit appears once its entry is read. A wrong address state changes which entry is read and so breaks the output sequence in the next RUN cycle. A miscounted fill shows as `out_valid` rising one cycle too early or too late after the 64th enabled cycle. Comparing every output against a bit-exact model under several seeds and enable duty patterns exposes each of these within one address period.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } shuf_state_e;

endpackage

// File: rtl/shuf_lfsr.sv
module shuf_lfsr #(
    parameter int             W       = 31,
    parameter logic [W-1:0]   TAPS    = W'(1) << (W - 1),
    parameter logic [W-1:0]   DEFAULT = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state,
    output logic         next_bit
);

    logic [W-1:0] state_q;
    logic [W-1:0] seed_eff;

    // Zero is the lock-up state of an XOR LFSR, so it is never accepted.
    assign seed_eff = (seed == '0) ? DEFAULT : seed;
    assign next_bit = ^(state_q & TAPS);
    assign state    = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEFAULT;
        end else if (load) begin
            state_q <= seed_eff;
        end else if (step) begin
            state_q <= {state_q[W-2:0], next_bit};
        end
    end

    // R8: the register never reaches the all-zero lock-up state
    p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0)
        else $error("LFSR reached all-zero state");

endmodule

// File: rtl/shuf_bitmem.sv
module shuf_bitmem #(
    parameter int AW    = 6,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data
);

    logic [DEPTH-1:0] cells;

    // The read is combinational and the write lands at the clock edge,
    // so a read and write to one address in a cycle returns the old bit.
    assign rd_data = cells[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/bit_shuffler.sv
module bit_shuffler
    import shuf_pkg::*;
#(
    parameter int                 PRI_W       = 31,
    parameter logic [PRI_W-1:0]   PRI_TAPS    = 31'h4800_0000,
    parameter logic [PRI_W-1:0]   PRI_DEFAULT = 31'h1,
    parameter int                 ADR_W       = 7,
    parameter logic [ADR_W-1:0]   ADR_TAPS    = 7'h60,
    parameter logic [ADR_W-1:0]   ADR_DEFAULT = 7'h1,
    parameter int                 AW          = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             seed_load,
    input  logic [PRI_W-1:0] pri_seed,
    input  logic [ADR_W-1:0] adr_seed,
    output logic             out_bit,
    output logic             out_valid
);

    localparam int            DEPTH    = 1 << AW;
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
    localparam int            ADR_PER  = (1 << ADR_W) - 1;
    localparam int            MISS_W   = ADR_W + 1;

    shuf_state_e     st_q, st_d;
    logic [AW-1:0]   fill_q, fill_d;

    logic            adv;
    logic            adr_step;
    logic [PRI_W-1:0] pri_state;
    logic [ADR_W-1:0] adr_state;
    logic            pri_bit;
    logic            adr_fb;
    logic [AW-1:0]   rd_addr;
    logic [AW-1:0]   wr_addr;
    logic            rd_data;

    assign adv      = en && !seed_load;
    assign adr_step = adv && (st_q == ST_RUN);
    assign rd_addr  = adr_state[AW-1:0];
    assign wr_addr  = (st_q == ST_FILL) ? fill_q : rd_addr;

    shuf_lfsr #(
        .W       (PRI_W),
        .TAPS    (PRI_TAPS),
        .DEFAULT (PRI_DEFAULT)
    ) u_pri (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_load),
        .seed     (pri_seed),
        .step     (adv),
        .state    (pri_state),
        .next_bit (pri_bit)
    );

    shuf_lfsr #(
        .W       (ADR_W),
        .TAPS    (ADR_TAPS),
        .DEFAULT (ADR_DEFAULT)
    ) u_adr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_load),
        .seed     (adr_seed),
        .step     (adr_step),
        .state    (adr_state),
        .next_bit (adr_fb)
    );

    shuf_bitmem #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) u_mem (
        .clk     (clk),
        .wr_en   (adv),
        .wr_addr (wr_addr),
        .wr_data (pri_bit),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        fill_d = fill_q;
        if (seed_load) begin
            st_d   = ST_FILL;
            fill_d = '0;
        end else if (en) begin
            unique case (st_q)
                ST_FILL: begin
                    fill_d = fill_q + AW'(1);
                    if (fill_q == LAST) begin
                        st_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    st_d = ST_RUN;
                end
                default: begin
                    st_d = ST_FILL;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_FILL;
            fill_q <= '0;
        end else begin
            st_q   <= st_d;
            fill_q <= fill_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= adr_step;
            if (adr_step) begin
                out_bit <= rd_data;
            end
        end
    end

    // Run steps since address 0 was last read (window checker for R4)
    logic [MISS_W-1:0] miss_q;
    always_ff @(posedge clk) begin
        if (!rst_n || seed_load) begin
            miss_q <= '0;
        end else if (adr_step) begin
            if (rd_addr == '0) begin
                miss_q <= '0;
            end else begin
                miss_q <= miss_q + MISS_W'(1);
            end
        end
    end

    // R4: address 0 is read at least once per address-generator period
    p_addr_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q < MISS_W'(ADR_PER))
        else $error("address 0 not visited within one period");

    // R4: the address generator stays put while filling
    p_addr_frozen_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && !seed_load) |=> $stable(adr_state))
        else $error("address LFSR moved during fill");

    // R2: no valid output follows a fill cycle
    p_fill_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL) |=> !out_valid)
        else $error("valid asserted during fill");

    // R7: idle cycles keep both generators unchanged
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_load) |=> ($stable(pri_state) && $stable(adr_state) && !out_valid))
        else $error("state moved while idle");

    // R8: a seed load restarts the fill from entry 0
    p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (st_q == ST_FILL && fill_q == '0 && !out_valid))
        else $error("seed load did not restart fill");

    // R9: a valid output only follows a RUN cycle
    p_valid_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(st_q == ST_RUN))
        else $error("valid without a preceding run cycle");

endmodule

// File: tb/bit_shuffler_test.sv
module bit_shuffler_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        seed_load = 1'b0;
    logic [30:0] pri_seed = '0;
    logic [6:0]  adr_seed = '0;
    logic        out_bit;
    logic        out_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    bit_shuffler uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .seed_load (seed_load),
        .pri_seed  (pri_seed),
        .adr_seed  (adr_seed),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    // Reference model state
    logic [30:0] m_pri;
    logic [6:0]  m_adr;
    bit          m_mem [64];
    int          m_fill;
    bit          m_run;
    bit          exp_valid;
    bit          exp_bit;
    bit          first_out;
    int          ones;
    int          outs;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pri = 31'h1;
        m_adr = 7'h1;
        m_fill = 0;
        m_run = 1'b0;
        exp_valid = 1'b0;
        exp_bit = 1'b0;
        first_out = 1'b1;
    endtask

    // One clock cycle: drive, let the edge pass, update the model, compare.
    task automatic cyc(input bit e, input bit l, input logic [30:0] sp, input logic [6:0] sa);
        string tag;
        bit    fb;
        bit    prev_bit;
        int    a;
        @(negedge clk);
        en = e;
        seed_load = l;
        pri_seed = sp;
        adr_seed = sa;
        prev_bit = exp_bit;
        @(posedge clk);
        if (l) begin
            m_pri = (sp == 0) ? 31'h1 : sp;
            m_adr = (sa == 0) ? 7'h1 : sa;
            m_fill = 0;
            m_run = 1'b0;
            exp_valid = 1'b0;
            first_out = 1'b1;
            tag = "R8";
        end else if (e) begin
            fb = m_pri[30] ^ m_pri[27];
            if (!m_run) begin
                m_mem[m_fill] = fb;
                m_pri = {m_pri[29:0], fb};
                if (m_fill == 63) m_run = 1'b1;
                m_fill++;
                exp_valid = 1'b0;
                tag = "R2";
            end else begin
                a = int'(m_adr[5:0]);
                exp_bit = m_mem[a];
                m_mem[a] = fb;
                m_pri = {m_pri[29:0], fb};
                m_adr = {m_adr[5:0], m_adr[6] ^ m_adr[5]};
                exp_valid = 1'b1;
                tag = first_out ? "R6" : "R3/R4/R5";
                first_out = 1'b0;
            end
        end else begin
            exp_valid = 1'b0;
            tag = "R7";
        end
        #2;
        chk(out_valid == exp_valid, {tag, " valid (R9)"}, int'(out_valid), int'(exp_valid));
        if (exp_valid) begin
            chk(out_bit == exp_bit, {tag, " bit"}, int'(out_bit), int'(exp_bit));
            outs++;
            if (out_bit) ones++;
        end else begin
            chk(out_bit == prev_bit, "R9 hold", int'(out_bit), int'(prev_bit));
            exp_bit = prev_bit;
        end
    endtask

    initial begin
        logic [30:0] sp_tab [6];
        logic [6:0]  sa_tab [6];
        sp_tab[0] = 31'h0;        sa_tab[0] = 7'h0;
        sp_tab[1] = 31'h1;        sa_tab[1] = 7'h7f;
        sp_tab[2] = 31'h5a5a_a5a5; sa_tab[2] = 7'h2b;
        sp_tab[3] = 31'h7fff_ffff; sa_tab[3] = 7'h40;
        sp_tab[4] = 31'h0012_3456; sa_tab[4] = 7'h0;
        sp_tab[5] = 31'h0;        sa_tab[5] = 7'h11;

        model_reset();
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

        // Default seeds straight out of reset (R1), continuous enable
        for (int i = 0; i < 64 + 1500; i++) cyc(1'b1, 1'b0, '0, '0);

        // Sweep seed pairs and enable duty patterns; load with en high (R8 priority)
        for (int c = 0; c < 6; c++) begin
            for (int d = 1; d <= 3; d++) begin
                cyc(1'b1, 1'b1, sp_tab[c], sa_tab[c]);
                for (int i = 0; i < 1200; i++) cyc((i % d) == 0, 1'b0, '0, '0);
            end
        end

        // Load in the middle of a fill restarts it (R8)
        cyc(1'b1, 1'b1, 31'h0abc_def1, 7'h33);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, '0, '0);
        cyc(1'b0, 1'b1, 31'h0abc_def1, 7'h33);
        for (int i = 0; i < 400; i++) cyc(1'b1, 1'b0, '0, '0);

        // Long-run fraction of ones (R10)
        cyc(1'b1, 1'b1, 31'h1357_9bdf, 7'h5d);
        for (int i = 0; i < 64; i++) cyc(1'b1, 1'b0, '0, '0);
        ones = 0;
        outs = 0;
        for (int i = 0; i < 32768; i++) cyc(1'b1, 1'b0, '0, '0);
        chk(outs == 32768, "R10 output count", outs, 32768);
        chk((ones * 100 >= outs * 45) && (ones * 100 <= outs * 55),
            "R10 ones fraction", ones, outs / 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule